// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Mapping

This block keeps the control-store address of a microprogrammed controller and chooses the following address once per clock. The sequencing field of the microinstruction at the current address arrives on the inputs. The field picks one of eight actions: step forward, jump, branch on a selected condition, merge or splice a target into the address, call a subroutine, return from one, or dispatch on the opcode of a machine instruction. Loops are written as conditional branches back to an earlier address.

Only one adder is present, and it is the +1 incrementer. A branch target either replaces the whole address, is ORed into it, or replaces only its low bits. A return-address stack of bounded depth holds the return addresses for subroutine calls. A call that would overflow the stack, or a return from an empty stack, leaves the address where it is and raises a sticky error flag. Opcode dispatch has three schemes, chosen at run time: fixed-size segments, a jump table at the bottom of the store, or a lookup table held in a parameter.

Top module: `ucs_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer sets `next_addr` to 0, sets `stk_err` to 0 and empties the return stack. A return issued right after reset is therefore an underflow.
- R2: `seq_op` = 0 (step) loads `next_addr` + 1 on the next edge. The sum wraps from the all-ones address to 0.
- R3: `seq_op` = 1 (jump) loads `br_target` on the next edge.
- R4: The branch condition is `cond_vec[cond_sel]` XOR `cond_inv`. With `seq_op` = 2, the sequencer loads `br_target` when the condition is true and `next_addr` + 1 when it is false.
- R5: With `seq_op` = 3, the sequencer loads `next_addr` OR `br_target` when the condition is true and `next_addr` + 1 when it is false.
- R6: With `seq_op` = 4, a true condition keeps the upper bits of `next_addr` and takes the low LOW_W bits (default 4) from `br_target`. A false condition loads `next_addr` + 1.
- R7: `seq_op` = 5 (call) with fewer than STK_DEPTH (default 4) entries stacked pushes `next_addr` + 1 and loads `br_target`.
- R8: `seq_op` = 6 (return) with a non-empty stack loads the most recently pushed address and pops it.
- R9: `seq_op` = 7 with `map_mode` = 0 loads the opcode followed by ADDR_W-OP_W zero bits (with defaults, opcode × 16).
- R10: `seq_op` = 7 with `map_mode` = 1 loads the opcode zero-extended to ADDR_W bits.
- R11: `seq_op` = 7 with `map_mode` = 2 or 3 loads entry `opcode` of the MAP_TABLE parameter. Entry i occupies bits [i*ADDR_W +: ADDR_W].
- R12: A call while STK_DEPTH entries are stacked keeps `next_addr` unchanged, sets `stk_err` and leaves the stack contents intact.
- R13: A return with an empty stack keeps `next_addr` unchanged and sets `stk_err`.
- R14: Once `stk_err` is set, it stays set until reset, whatever the later operations are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seq_op | input | 3 | Sequencing action of the current microinstruction |
| br_target | input | ADDR_W | Branch, call or splice target |
| cond_sel | input | SEL_W | Selects one bit of `cond_vec` |
| cond_inv | input | 1 | Inverts the selected condition |
| cond_vec | input | 2**SEL_W | Condition inputs |
| opcode | input | OP_W | Machine-instruction opcode used for dispatch |
| map_mode | input | 2 | Opcode dispatch scheme |
| next_addr | output | ADDR_W | Control-store address for the next fetch |
| stk_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The bench drives calls and returns that meet the stack bounds, so that stack fault detection lands in the same cycle as call or return sequencing. It stacks four calls and then issues a fifth. It judges that the address holds, that the flag rises, and that the four earlier return addresses still come back in reverse order. It then issues one return too many, which must again hold the address while the flag stays set.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
   typedef enum logic [2:0] {
      SQ_INC  = 3'd0,
      SQ_JMP  = 3'd1,
      SQ_CJMP = 3'd2,
      SQ_COR  = 3'd3,
      SQ_CLOW = 3'd4,
      SQ_CALL = 3'd5,
      SQ_RET  = 3'd6,
      SQ_MAP  = 3'd7
   } sq_op_e;

   typedef enum logic [1:0] {
      MM_SEG  = 2'd0,
      MM_ZEXT = 2'd1,
      MM_TBL  = 2'd2,
      MM_TBLB = 2'd3
   } map_mode_e;
endpackage

// File: rtl/ucs_cond.sv
module ucs_cond #(
   parameter int SEL_W = 3,
   localparam int NCOND = 1 << SEL_W
) (
   input  logic [NCOND-1:0] cond_vec,
   input  logic [SEL_W-1:0] sel,
   input  logic             inv,
   output logic             taken
);
   if (SEL_W < 1) begin : g_bad_sel
      $error("ucs_cond: SEL_W must be at least 1");
   end

   assign taken = cond_vec[sel] ^ inv;
endmodule

// File: rtl/ucs_stack.sv
module ucs_stack #(
   parameter int ADDR_W = 8,
   parameter int DEPTH  = 4,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic              pop,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] top,
   output logic              full,
   output logic              empty,
   output logic [CNT_W-1:0]  count
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("ucs_stack: DEPTH must be at least 2");
   end

   logic [ADDR_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  tos;

   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign empty = (cnt_q == '0);
   assign count = cnt_q;
   assign tos   = cnt_q - 1'b1;
   assign top   = empty ? '0 : mem[tos[IDX_W-1:0]];

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (push && !full) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (pop && !empty) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst && push && !full) begin
         mem[cnt_q[IDX_W-1:0]] <= wdata;
      end
   end
endmodule

// File: rtl/ucs_map.sv
module ucs_map #(
   parameter int ADDR_W = 8,
   parameter int OP_W   = 4,
   parameter logic [(2**OP_W)*ADDR_W-1:0] TABLE = '0,
   localparam int SH = ADDR_W - OP_W
) (
   input  logic [OP_W-1:0]   op,
   input  logic [1:0]        mode,
   output logic [ADDR_W-1:0] addr
);
   import ucs_pkg::*;

   if (OP_W > ADDR_W) begin : g_bad_op
      $error("ucs_map: OP_W must not exceed ADDR_W");
   end

   logic [ADDR_W-1:0] seg_addr;
   logic [ADDR_W-1:0] zext_addr;
   logic [ADDR_W-1:0] tbl [2**OP_W];

   if (SH == 0) begin : g_full_op
      assign seg_addr  = op;
      assign zext_addr = op;
   end else begin : g_pad_op
      assign seg_addr  = {op, {SH{1'b0}}};
      assign zext_addr = {{SH{1'b0}}, op};
   end

   for (genvar i = 0; i < 2**OP_W; i++) begin : g_tbl
      assign tbl[i] = TABLE[i*ADDR_W +: ADDR_W];
   end

   always_comb begin
      unique case (map_mode_e'(mode))
         MM_SEG:  addr = seg_addr;
         MM_ZEXT: addr = zext_addr;
         default: addr = tbl[op];
      endcase
   end
endmodule

// File: rtl/ucs_seq.sv
module ucs_seq #(
   parameter int ADDR_W    = 8,
   parameter int OP_W      = 4,
   parameter int STK_DEPTH = 4,
   parameter int SEL_W     = 3,
   parameter int LOW_W     = 4,
   parameter logic [(2**OP_W)*ADDR_W-1:0] MAP_TABLE = '0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [2:0]            seq_op,
   input  logic [ADDR_W-1:0]     br_target,
   input  logic [SEL_W-1:0]      cond_sel,
   input  logic                  cond_inv,
   input  logic [2**SEL_W-1:0]   cond_vec,
   input  logic [OP_W-1:0]       opcode,
   input  logic [1:0]            map_mode,
   output logic [ADDR_W-1:0]     next_addr,
   output logic                  stk_err
);
   import ucs_pkg::*;

   localparam int CNT_W = $clog2(STK_DEPTH + 1);
   localparam logic [ADDR_W-1:0] LOW_MASK = {{(ADDR_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};

   if (LOW_W < 1 || LOW_W >= ADDR_W) begin : g_bad_low
      $error("ucs_seq: LOW_W must lie in 1..ADDR_W-1");
   end

   logic [ADDR_W-1:0] upc_q, upc_d, inc_addr, map_addr, ret_addr;
   logic              err_q, err_d;
   logic              taken, push, pop, full, empty;
   logic [CNT_W-1:0]  stk_cnt;

   ucs_cond #(.SEL_W(SEL_W)) u_cond (
      .cond_vec(cond_vec), .sel(cond_sel), .inv(cond_inv), .taken(taken)
   );

   ucs_map #(.ADDR_W(ADDR_W), .OP_W(OP_W), .TABLE(MAP_TABLE)) u_map (
      .op(opcode), .mode(map_mode), .addr(map_addr)
   );

   ucs_stack #(.ADDR_W(ADDR_W), .DEPTH(STK_DEPTH)) u_stack (
      .clk(clk), .rst(rst), .push(push), .pop(pop), .wdata(inc_addr),
      .top(ret_addr), .full(full), .empty(empty), .count(stk_cnt)
   );

   assign inc_addr = upc_q + 1'b1;

   always_comb begin
      upc_d = inc_addr;
      err_d = err_q;
      push  = 1'b0;
      pop   = 1'b0;
      unique case (sq_op_e'(seq_op))
         SQ_INC:  upc_d = inc_addr;
         SQ_JMP:  upc_d = br_target;
         SQ_CJMP: upc_d = taken ? br_target : inc_addr;
         SQ_COR:  upc_d = taken ? (upc_q | br_target) : inc_addr;
         SQ_CLOW: upc_d = taken ? ((upc_q & ~LOW_MASK) | (br_target & LOW_MASK)) : inc_addr;
         SQ_CALL: begin
            if (full) begin
               upc_d = upc_q;
               err_d = 1'b1;
            end else begin
               upc_d = br_target;
               push  = 1'b1;
            end
         end
         SQ_RET: begin
            if (empty) begin
               upc_d = upc_q;
               err_d = 1'b1;
            end else begin
               upc_d = ret_addr;
               pop   = 1'b1;
            end
         end
         SQ_MAP:  upc_d = map_addr;
         default: upc_d = inc_addr;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         upc_q <= '0;
         err_q <= 1'b0;
      end else begin
         upc_q <= upc_d;
         err_q <= err_d;
      end
   end

   assign next_addr = upc_q;
   assign stk_err   = err_q;
endmodule

// File: rtl/ucs_seq_chk.sv
module ucs_seq_chk #(
   parameter int ADDR_W    = 8,
   parameter int STK_DEPTH = 4,
   localparam int CNT_W    = $clog2(STK_DEPTH + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic [2:0]        seq_op,
   input logic [ADDR_W-1:0] br_target,
   input logic [ADDR_W-1:0] next_addr,
   input logic              stk_err,
   input logic [CNT_W-1:0]  stk_cnt
);
   // R2
   inc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (seq_op == 3'd0) |=> next_addr == ADDR_W'($past(next_addr) + 1'b1));

   // R3
   jmp_load_chk: assert property (@(posedge clk) disable iff (rst)
      (seq_op == 3'd1) |=> next_addr == $past(br_target));

   // R7
   call_push_chk: assert property (@(posedge clk) disable iff (rst)
      (seq_op == 3'd5 && stk_cnt != CNT_W'(STK_DEPTH))
      |=> (next_addr == $past(br_target)) && (stk_cnt == CNT_W'($past(stk_cnt) + 1'b1)));

   // R12
   ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (seq_op == 3'd5 && stk_cnt == CNT_W'(STK_DEPTH))
      |=> stk_err && $stable(next_addr) && $stable(stk_cnt));

   // R12
   cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
      stk_cnt <= CNT_W'(STK_DEPTH));

   // R13
   unf_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (seq_op == 3'd6 && stk_cnt == '0) |=> stk_err && $stable(next_addr));

   // R14
   err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      stk_err |=> stk_err);
endmodule

bind ucs_seq ucs_seq_chk #(.ADDR_W(ADDR_W), .STK_DEPTH(STK_DEPTH)) u_chk (
   .clk(clk), .rst(rst), .seq_op(seq_op), .br_target(br_target),
   .next_addr(next_addr), .stk_err(stk_err), .stk_cnt(stk_cnt)
);

// File: tb/ucs_seq_tb.sv
module ucs_seq_tb;
   localparam int AW = 8;
   localparam int OW = 4;

   function automatic logic [AW-1:0] tbl_at(input int i);
      return AW'(i * 13 + 7);
   endfunction

   function automatic logic [(2**OW)*AW-1:0] mk_tbl();
      logic [(2**OW)*AW-1:0] t;
      t = '0;
      for (int i = 0; i < 2**OW; i++) t[i*AW +: AW] = tbl_at(i);
      return t;
   endfunction

   localparam logic [(2**OW)*AW-1:0] TBL = mk_tbl();

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [2:0]    seq_op = '0;
   logic [AW-1:0] br_target = '0;
   logic [2:0]    cond_sel = '0;
   logic          cond_inv = 1'b0;
   logic [7:0]    cond_vec = '0;
   logic [OW-1:0] opcode = '0;
   logic [1:0]    map_mode = '0;
   logic [AW-1:0] next_addr;
   logic          stk_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   ucs_seq #(.ADDR_W(AW), .OP_W(OW), .STK_DEPTH(4), .SEL_W(3), .LOW_W(4),
             .MAP_TABLE(TBL)) u_dut (
      .clk(clk), .rst(rst), .seq_op(seq_op), .br_target(br_target),
      .cond_sel(cond_sel), .cond_inv(cond_inv), .cond_vec(cond_vec),
      .opcode(opcode), .map_mode(map_mode), .next_addr(next_addr),
      .stk_err(stk_err)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic [2:0] op, input logic [AW-1:0] tgt = '0,
                       input logic [2:0] sel = '0, input logic inv = 1'b0);
      seq_op = op; br_target = tgt; cond_sel = sel; cond_inv = inv;
      @(posedge clk); #1;
      seq_op = 3'd0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      seq_op = 3'd1; br_target = 8'h77;
      repeat (2) @(posedge clk);
      #1;
      check("R1 addr", next_addr, 0);
      check("R1 err", stk_err, 0);
      rst = 1'b0;
      seq_op = 3'd0;
   endtask

   task automatic t_inc();
      step(3'd0); step(3'd0); step(3'd0);
      check("R2 step", next_addr, 3);
      step(3'd1, 8'hFF);
      check("R3 jump", next_addr, 8'hFF);
      step(3'd0);
      check("R2 wrap", next_addr, 0);
   endtask

   task automatic t_cond();
      cond_vec = 8'b0010_0100;
      step(3'd1, 8'h10);
      step(3'd2, 8'h40, 3'd2, 1'b0);
      check("R4 taken", next_addr, 8'h40);
      step(3'd2, 8'h10, 3'd3, 1'b0);
      check("R4 not taken", next_addr, 8'h41);
      step(3'd2, 8'h20, 3'd3, 1'b1);
      check("R4 inverted", next_addr, 8'h20);
      step(3'd2, 8'h20, 3'd2, 1'b1);
      check("R4 inverted false", next_addr, 8'h21);
   endtask

   task automatic t_or();
      step(3'd1, 8'h20);
      step(3'd3, 8'h05, 3'd5, 1'b0);
      check("R5 or taken", next_addr, 8'h25);
      step(3'd3, 8'h05, 3'd0, 1'b0);
      check("R5 or not taken", next_addr, 8'h26);
   endtask

   task automatic t_low();
      step(3'd4, 8'hF9, 3'd2, 1'b0);
      check("R6 splice taken", next_addr, 8'h29);
      step(3'd4, 8'hF9, 3'd1, 1'b0);
      check("R6 splice not taken", next_addr, 8'h2A);
   endtask

   task automatic t_map();
      opcode = 4'hB;
      map_mode = 2'd0; step(3'd7);
      check("R9 segment", next_addr, 8'hB0);
      map_mode = 2'd1; step(3'd7);
      check("R10 zero-extend", next_addr, 8'h0B);
      map_mode = 2'd2; step(3'd7);
      check("R11 table", next_addr, tbl_at(11));
      opcode = 4'h3; map_mode = 2'd3; step(3'd7);
      check("R11 table alt", next_addr, tbl_at(3));
   endtask

   task automatic t_stack();
      step(3'd1, 8'h50);
      step(3'd5, 8'h60);
      check("R7 call", next_addr, 8'h60);
      step(3'd0);
      step(3'd5, 8'h70);
      step(3'd5, 8'h80);
      step(3'd5, 8'h90);
      check("R7 fourth call", next_addr, 8'h90);
      check("R12 no err yet", stk_err, 0);
      step(3'd5, 8'hA0);
      check("R12 overflow hold", next_addr, 8'h90);
      check("R12 overflow flag", stk_err, 1);
      step(3'd6); check("R8 ret 1", next_addr, 8'h81);
      step(3'd6); check("R8 ret 2", next_addr, 8'h71);
      step(3'd6); check("R8 ret 3", next_addr, 8'h62);
      step(3'd6); check("R12 intact ret 4", next_addr, 8'h51);
      step(3'd6); check("R13 underflow hold", next_addr, 8'h51);
      step(3'd0);
      check("R14 sticky addr", next_addr, 8'h52);
      check("R14 sticky err", stk_err, 1);
   endtask

   task automatic t_post_reset();
      do_reset();
      step(3'd6);
      check("R1 empty after reset addr", next_addr, 0);
      check("R13 underflow flag", stk_err, 1);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      @(posedge clk); #1;
      do_reset();
      t_inc();
      t_cond();
      t_or();
      t_low();
      t_map();
      t_stack();
      t_post_reset();
      do_reset();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule